// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status Unit

This block collects the event pulses of an SD/MMC host controller into sticky status bits and turns them into one interrupt line. Each event input has a fixed bit position. A one-cycle pulse on an event input sets its bit in the raw status register, and the bit stays set until software clears it. Software clears bits by writing ones to the raw status register. Bits written as zero keep their state. If an event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.

A mask register chooses which raw bits count toward the interrupt. The masked status register is read-only and returns raw status AND mask. The interrupt output is the OR of all masked bits, gated by an enable bit in the control register, and it comes from a flop so it cannot glitch. Two summary outputs, `anyErr` and `anyDone`, report whether any raw bit in the error group or the completion group is set. Neither summary depends on the mask.

Register map (byte offsets on `busAddr`): control 0x00, mask 0x30, masked status 0x34, raw status 0x38. Reads are combinational from `busAddr`. Writes take effect on the clock edge where `busWrEn` is high.

Top module: `isu_top`

## Requirements
- R1: While `rstN` is low and after reset, the raw status, mask and control enable are all zero, `irqOut`, `anyErr` and `anyDone` are low, and every register reads as zero.
- R2: A pulse on `evtIn[k]`, where k is an implemented bit, sets raw status bit k at the next clock edge. The bit then stays set with no further events until software clears it. Implemented bits are 1 to 16, 30 and 31 (bit map: 1 response error, 2 command done, 3 data over, 4 transmit request, 5 receive request, 6 response CRC error, 7 data CRC error, 8 response timeout, 9 data timeout, 10 voltage switch done, 11 FIFO under/overrun, 12 hardware locked, 13 start-bit error, 14 auto-command done, 15 end-bit error, 16 SDIO interrupt, 30 card inserted, 31 card removed).
- R3: A write to offset 0x38 clears every raw bit written as one at that clock edge. Raw bits written as zero are unchanged.
- R4: When an event and a clear for the same bit fall in the same cycle, the bit is set after that edge.
- R5: A read of offset 0x34 returns raw status AND mask. A write to offset 0x34 changes no register.
- R6: The mask at offset 0x30 is read/write for the implemented bits. Every other mask bit reads zero.
- R7: `irqOut` in a cycle equals (enable AND OR of raw AND mask) as it stood in the previous cycle.
- R8: The interrupt enable is bit 4 of the control register at offset 0x00. Every other control bit reads zero. With the enable at zero, `irqOut` stays low whatever the masked status.
- R9: `anyErr` is high exactly when a raw bit in the error group {1,6,7,8,9,11,12,13,15} is set.
- R10: `anyDone` is high exactly when a raw bit in the completion group {2,3,10,14} is set.
- R11: Events on the unimplemented bits 0 and 17 to 29 are ignored, and those raw status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| evtIn | input | 32 | Event pulses, one per status bit position |
| irqOut | output | 1 | Registered interrupt line |
| anyErr | output | 1 | Some error-group raw bit is set |
| anyDone | output | 1 | Some completion-group raw bit is set |

## Verification
The assertions check on every cycle that an event always sets its bit, that a raw bit only falls under a clear write naming it, that an event beats a simultaneous clear, and that the interrupt follows the previous cycle's enabled masked status. They also check that the masked status read matches raw AND mask, and that unimplemented bits never hold state. Only the bench scenarios can show the register map from outside the block. These scenarios cover writes to the read-only masked view having no effect, control bits other than the enable reading zero, and the summary groups matching the exact bit lists. They also show the one-cycle lag of `irqOut` being observed at the pins under mixed random traffic.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam int DATA_W = 32;

  // register byte offsets
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h30;
  localparam logic [7:0] OFF_MSTAT = 8'h34;
  localparam logic [7:0] OFF_RAW   = 8'h38;

  // control bit carrying the interrupt enable
  localparam int EN_BIT = 4;

  // status bit positions
  localparam int B_RSP_ERR   = 1;
  localparam int B_CMD_DONE  = 2;
  localparam int B_DAT_OVER  = 3;
  localparam int B_TX_REQ    = 4;
  localparam int B_RX_REQ    = 5;
  localparam int B_RSP_CRC   = 6;
  localparam int B_DAT_CRC   = 7;
  localparam int B_RSP_TO    = 8;
  localparam int B_DAT_TO    = 9;
  localparam int B_VSW_DONE  = 10;
  localparam int B_FIFO_RUN  = 11;
  localparam int B_HW_LOCK   = 12;
  localparam int B_START_ERR = 13;
  localparam int B_ACMD_DONE = 14;
  localparam int B_END_ERR   = 15;
  localparam int B_SDIO      = 16;
  localparam int B_CARD_IN   = 30;
  localparam int B_CARD_OUT  = 31;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  localparam logic [DATA_W-1:0] ERR_MASK =
      (ONE << B_RSP_ERR) | (ONE << B_RSP_CRC) | (ONE << B_DAT_CRC) |
      (ONE << B_RSP_TO) | (ONE << B_DAT_TO) | (ONE << B_FIFO_RUN) |
      (ONE << B_HW_LOCK) | (ONE << B_START_ERR) | (ONE << B_END_ERR);

  localparam logic [DATA_W-1:0] DONE_MASK =
      (ONE << B_CMD_DONE) | (ONE << B_DAT_OVER) |
      (ONE << B_VSW_DONE) | (ONE << B_ACMD_DONE);

  localparam logic [DATA_W-1:0] XFER_MASK =
      (ONE << B_TX_REQ) | (ONE << B_RX_REQ) | (ONE << B_SDIO);

  localparam logic [DATA_W-1:0] CARD_MASK =
      (ONE << B_CARD_IN) | (ONE << B_CARD_OUT);

  localparam logic [DATA_W-1:0] VALID_MASK =
      ERR_MASK | DONE_MASK | XFER_MASK | CARD_MASK;

  // strobes from decode to datapath
  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic rawClr;
  } regStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_MASK,
    RD_MSTAT,
    RD_RAW
  } rdSel_t;

endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strb,
  output rdSel_t            rdSel
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFF_MSTAT);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);

  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    case (busAddr)
      A_CTRL: begin
        rdSel       = RD_CTRL;
        strb.ctrlWr = busWrEn;
      end
      A_MASK: begin
        rdSel       = RD_MASK;
        strb.maskWr = busWrEn;
      end
      A_MSTAT: begin
        // read-only view: writes produce no strobe
        rdSel = RD_MSTAT;
      end
      A_RAW: begin
        rdSel       = RD_RAW;
        strb.rawClr = busWrEn;
      end
      default: begin
        rdSel = RD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/isu_datapath.sv
module isu_datapath
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rawStat,
  output logic [DATA_W-1:0] maskReg,
  output logic              globalEn,
  output logic              irqOut,
  output logic              anyErr,
  output logic              anyDone
);

  logic [DATA_W-1:0] mStat;
  logic              unusedBits;

  // event and write bits at positions with no status bit
  assign unusedBits = ^((evtIn | wrData) & ~VALID_MASK);

  // one sticky status flop and one mask flop per implemented bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (VALID_MASK[i]) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rawStat[i] <= 1'b0;
          maskReg[i] <= 1'b0;
        end else begin
          if (evtIn[i]) begin
            rawStat[i] <= 1'b1;
          end else if (strb.rawClr && wrData[i]) begin
            rawStat[i] <= 1'b0;
          end
          if (strb.maskWr) begin
            maskReg[i] <= wrData[i];
          end
        end
      end
    end else begin : g_dead
      assign rawStat[i] = 1'b0;
      assign maskReg[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
    end else if (strb.ctrlWr) begin
      globalEn <= wrData[EN_BIT];
    end
  end

  assign mStat = rawStat & maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= globalEn & (|mStat);
    end
  end

  assign anyErr  = |(rawStat & ERR_MASK);
  assign anyDone = |(rawStat & DONE_MASK);

  always_comb begin
    case (rdSel)
      RD_CTRL:  rdData = DATA_W'(globalEn) << EN_BIT;
      RD_MASK:  rdData = maskReg;
      RD_MSTAT: rdData = mStat;
      RD_RAW:   rdData = rawStat;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] evtIn,
  output logic              irqOut,
  output logic              anyErr,
  output logic              anyDone
);

  regStrobe_t        strb;
  rdSel_t            rdSel;
  logic [DATA_W-1:0] rawStat;
  logic [DATA_W-1:0] maskReg;
  logic              globalEn;

  isu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  isu_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .evtIn    (evtIn),
    .rdData   (busRdData),
    .rawStat  (rawStat),
    .maskReg  (maskReg),
    .globalEn (globalEn),
    .irqOut   (irqOut),
    .anyErr   (anyErr),
    .anyDone  (anyDone)
  );

endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] evtIn,
  input logic              irqOut,
  input logic              anyErr,
  input logic              anyDone,
  input logic [DATA_W-1:0] rawStat,
  input logic [DATA_W-1:0] maskReg,
  input logic              globalEn
);

  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] liveEvt;

  assign clrVec  = (busWrEn && busAddr == ADDR_W'(OFF_RAW)) ? busWrData : '0;
  assign liveEvt = evtIn & VALID_MASK;

  // R2: every live event is visible in raw status after the edge
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (liveEvt != '0) |=> ((rawStat & $past(liveEvt)) == $past(liveEvt)));

  // R3: a raw bit only falls where a clear write named it
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(rawStat) & ~rawStat) & ~$past(clrVec)) == '0));

  // R3: cleared bits with no competing event are low after the edge
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & ~evtIn) != '0) |=> ((rawStat & $past(clrVec & ~evtIn)) == '0));

  // R4: event beats a simultaneous clear
  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((clrVec & liveEvt) != '0) |=>
      ((rawStat & $past(clrVec & liveEvt)) == $past(clrVec & liveEvt)));

  // R5: masked status view
  assert_mstat_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_MSTAT)) |-> (busRdData == (rawStat & maskReg)));

  // R7: interrupt follows last cycle's enabled masked status
  assert_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(globalEn && ((rawStat & maskReg) != '0)));

  // R9: error summary can only rise after an error-group event
  assert_err_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyErr) |-> ($past(evtIn & ERR_MASK) != '0));

  // R10: completion summary can only rise after a done-group event
  assert_done_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyDone) |-> ($past(evtIn & DONE_MASK) != '0));

  // R11: no state on unimplemented positions
  assert_dead_bits_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStat | maskReg) & ~VALID_MASK) == '0);

endmodule

bind isu_top isu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .evtIn     (evtIn),
  .irqOut    (irqOut),
  .anyErr    (anyErr),
  .anyDone   (anyDone),
  .rawStat   (rawStat),
  .maskReg   (maskReg),
  .globalEn  (globalEn)
);

// File: tb/isu_top_tb.sv
module isu_top_tb;

  localparam logic [31:0] VALID = 32'hC001_FFFE;
  localparam logic [31:0] ERRG  = 32'h0000_BBC2;
  localparam logic [31:0] DONEG = 32'h0000_440C;
  localparam logic [7:0]  A_CTRL  = 8'h00;
  localparam logic [7:0]  A_MASK  = 8'h30;
  localparam logic [7:0]  A_MSTAT = 8'h34;
  localparam logic [7:0]  A_RAW   = 8'h38;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] evtIn = '0;
  logic        irqOut, anyErr, anyDone;

  int checks = 0;
  int errors = 0;

  logic [31:0] expRaw = '0;
  logic [31:0] expMask = '0;
  logic        expEn = 1'b0;
  logic        expIrq = 1'b0;

  always #10 clk = ~clk;

  isu_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .evtIn(evtIn),
    .irqOut(irqOut), .anyErr(anyErr), .anyDone(anyDone)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlView(input logic en);
    return {27'd0, en, 4'd0};
  endfunction

  task automatic readChk(input logic [7:0] addr, input logic [31:0] exp, input string tag);
    busAddr = addr;
    #1;
    chk(tag, busRdData, exp);
  endtask

  // one clock: drive event and optional write, update model, check pins
  task automatic step(input logic [31:0] evt, input logic wr,
                      input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] clr;
    @(negedge clk);
    evtIn = evt; busWrEn = wr; busAddr = addr; busWrData = data;
    @(posedge clk);
    clr    = (wr && addr == A_RAW) ? data : '0;
    expIrq = expEn && ((expRaw & expMask) != 0);
    expRaw = ((expRaw & ~clr) | evt) & VALID;
    if (wr && addr == A_MASK) expMask = data & VALID;
    if (wr && addr == A_CTRL) expEn = data[4];
    #2;
    evtIn = '0; busWrEn = 1'b0; busAddr = A_RAW;
    #1;
    chk("R7 irqOut", {31'd0, irqOut}, {31'd0, expIrq});
    chk("R9 anyErr", {31'd0, anyErr}, {31'd0, (expRaw & ERRG) != 0});
    chk("R10 anyDone", {31'd0, anyDone}, {31'd0, (expRaw & DONEG) != 0});
    chk("R2 raw", busRdData, expRaw);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state, events during reset ignored
    evtIn = 32'hFFFF_FFFF;
    #25;
    readChk(A_RAW, 32'h0, "R1 raw in reset");
    evtIn = '0;
    readChk(A_MASK, 32'h0, "R1 mask in reset");
    readChk(A_CTRL, 32'h0, "R1 ctrl in reset");
    chk("R1 irq in reset", {31'd0, irqOut}, 32'h0);
    chk("R1 anyErr in reset", {31'd0, anyErr}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    // R6: mask readback with unimplemented bits dropped
    step('0, 1'b1, A_MASK, 32'hFFFF_FFFF);
    readChk(A_MASK, VALID, "R6 mask readback");
    // R8: only bit 4 of control is kept
    step('0, 1'b1, A_CTRL, 32'hFFFF_FFFF);
    readChk(A_CTRL, 32'h10, "R8 ctrl only enable");

    // R2/R7: command done sets, irq one cycle later
    step(32'h4, 1'b0, A_RAW, '0);
    chk("R7 irq not yet", {31'd0, irqOut}, 32'h0);
    step('0, 1'b0, A_RAW, '0);
    chk("R7 irq asserted", {31'd0, irqOut}, 32'h1);
    step('0, 1'b0, A_RAW, '0);
    readChk(A_RAW, 32'h4, "R2 sticky");

    // R3: zeros have no effect, ones clear
    step('0, 1'b1, A_RAW, 32'h0);
    readChk(A_RAW, 32'h4, "R3 zero write keeps");
    step('0, 1'b1, A_RAW, 32'h4);
    readChk(A_RAW, 32'h0, "R3 one clears");
    step('0, 1'b0, A_RAW, '0);
    chk("R7 irq drops", {31'd0, irqOut}, 32'h0);

    // R4: event and clear together
    step(32'h8000_0002, 1'b0, A_RAW, '0);
    step(32'h0000_0002, 1'b1, A_RAW, 32'h8000_0002);
    readChk(A_RAW, 32'h2, "R4 event wins");

    // R5: masked view and write ignored there
    step(32'h0001_0000, 1'b1, A_MASK, 32'h0001_0000);
    readChk(A_MSTAT, 32'h0001_0000, "R5 masked view");
    step('0, 1'b1, A_MSTAT, 32'hFFFF_FFFF);
    readChk(A_MSTAT, 32'h0001_0000, "R5 write ignored mstat");
    readChk(A_MASK, 32'h0001_0000, "R5 write ignored mask");
    readChk(A_RAW, 32'h0001_0002, "R5 write ignored raw");

    // R8: enable off holds irq low
    step('0, 1'b1, A_CTRL, 32'hFFFF_FFEF);
    step('0, 1'b0, A_RAW, '0);
    chk("R8 irq gated", {31'd0, irqOut}, 32'h0);

    // R11: unimplemented bits ignored
    step(32'h3FFE_0001, 1'b0, A_RAW, '0);
    readChk(A_RAW, 32'h0001_0002, "R11 dead events");

    // R9/R10: walk group bits individually
    step('0, 1'b1, A_RAW, 32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) begin
      step(32'h1 << b, 1'b0, A_RAW, '0);
      step('0, 1'b1, A_RAW, 32'hFFFF_FFFF);
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ev, dat;
      int op;
      ev  = $urandom & $urandom & $urandom;
      dat = $urandom;
      op  = $urandom % 6;
      case (op)
        2: step(ev, 1'b1, A_CTRL, dat);
        3: step(ev, 1'b1, A_MASK, dat);
        4: step(ev, 1'b1, A_RAW, dat);
        5: step(ev, 1'b1, A_MSTAT, dat);
        default: step(ev, 1'b0, A_RAW, '0);
      endcase
      if (n % 8 == 0) begin
        readChk(A_MSTAT, expRaw & expMask, "R5 random mstat");
        readChk(A_MASK, expMask, "R6 random mask");
        readChk(A_CTRL, ctrlView(expEn), "R8 random ctrl");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule